// File: doc/BRIEF.md
# Page Write Buffer and Programming Sequencer

This block sits between the serial command engine of a small non-volatile memory and its storage array. Once a write command and its start address have been decoded, the block gathers the data bytes that follow into a page-sized latch. It keeps a per-location mask of which latch slots were loaded, and it marks each slot as permitted or blocked by the protection logic as the byte arrives. The column pointer wraps inside the page, so a long burst overwrites earlier slots of the same page and never moves into the next one.

When chip select rises, the block checks the bit position reported by the serial engine. A programming cycle starts only if the rise lands exactly on a byte boundary and at least one data byte has arrived. While it runs, the block issues one array write strobe for each loaded and permitted slot, in ascending column order. It holds a busy flag for a fixed, parameterised number of clock cycles, forces status reads to return all ones, and refuses every other command. In the last busy cycle it pulses a request to clear the write-enable latch. A write that arrives while write-enable is off is dropped. A chip-select rise that comes mid-byte, or after no data bytes at all, abandons the write without changing write-enable.

Top module: `page_wr_ctrl`

## Requirements
- R1: Data byte k of a write whose start address has column c goes to column (c + k) mod PAGE_BYTES of the start page; the page part of the address never changes within one write.
- R2: A programming cycle starts only on a chip-select rise with bit_pos_i equal to 0; any other bit position abandons the write, with no array strobe, no busy and no write-enable clear.
- R3: busy_o goes high in the cycle after the accepted chip-select rise and stays high for exactly max(PROG_CYCLES, PAGE_BYTES) cycles.
- R4: While busy_o is high, stat_o reads 8'hFF; otherwise it equals stat_i.
- R5: While busy_o is high, op_accept_o is high only for an opcode flagged as a status read; write starts arriving during that time are ignored entirely.
- R6: wen_clr_o pulses for exactly one cycle per programming cycle, in the last cycle that busy_o is high.
- R7: A write start seen while wen_i is 0 loads nothing and leads to no programming cycle.
- R8: A byte loaded while permit_i is 0 is never written to the array.
- R9: Each loaded and permitted column is strobed exactly once per programming cycle, and no other column is written.
- R10: A write with no data bytes, closed by a chip-select rise, starts no programming cycle and does not pulse wen_clr_o.
- R11: During loading, load_addr_o shows the full array address that the next data byte will take.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_start_i | input | 1 | One-cycle pulse: write command and address decoded |
| start_addr_i | input | ADDR_W | Start address of the write |
| wen_i | input | 1 | Current write-enable latch state |
| byte_valid_i | input | 1 | One-cycle pulse: data byte complete |
| byte_i | input | 8 | Data byte |
| load_addr_o | output | ADDR_W | Address the next data byte will take |
| permit_i | input | 1 | Protection verdict for load_addr_o |
| cs_rise_i | input | 1 | One-cycle pulse: chip select went high |
| bit_pos_i | input | 3 | Bit count within the current byte at chip-select rise |
| op_valid_i | input | 1 | An opcode has been decoded |
| op_is_rdsr_i | input | 1 | The decoded opcode is a status read |
| op_accept_o | output | 1 | The decoded opcode may execute |
| stat_i | input | 8 | Status byte from the status logic |
| stat_o | output | 8 | Status byte as seen by a status read |
| arr_we_o | output | 1 | Array write strobe |
| arr_addr_o | output | ADDR_W | Array write address |
| arr_data_o | output | 8 | Array write data |
| busy_o | output | 1 | Programming cycle in progress |
| wen_clr_o | output | 1 | One-cycle request to clear write-enable |

## Verification
Every cycle, the assertions check the following: each busy window lasts the programming length; every busy window begins right after a chip-select rise on a byte boundary; strobes and the write-enable clear happen only while busy; strobes within one cycle stay on a single page in rising column order; and non-status opcodes are refused while busy. Some properties are visible only in the bench's scenarios. These are the page wrap of long bursts, the drop of protected bytes, the exact set of columns committed, and the silence after mid-byte rises, empty writes and writes without write-enable. The bench shows them by comparing a modelled array image against the strobes it observed, over a sweep of every start column and burst length.

// File: rtl/pwb_pkg.sv
package pwb_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOAD = 2'd1,
    ST_PROG = 2'd2
  } pwb_state_e;
endpackage

// File: rtl/pwb_col_ctr.sv
module pwb_col_ctr #(
  parameter int PAGE_BYTES = 32,
  localparam int COL_W = $clog2(PAGE_BYTES)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [COL_W-1:0] load_val_i,
  input  logic             inc_i,
  output logic [COL_W-1:0] col_o
);
  localparam logic [COL_W-1:0] LAST_COL = COL_W'(PAGE_BYTES - 1);

  logic [COL_W-1:0] col_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      col_q <= '0;
    end else if (load_i) begin
      col_q <= load_val_i;
    end else if (inc_i) begin
      col_q <= (col_q == LAST_COL) ? '0 : col_q + 1'b1;
    end
  end

  assign col_o = col_q;
endmodule

// File: rtl/pwb_page_latch.sv
module pwb_page_latch #(
  parameter int PAGE_BYTES = 32,
  localparam int COL_W = $clog2(PAGE_BYTES)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic             wr_i,
  input  logic [COL_W-1:0] wcol_i,
  input  logic [7:0]       wdata_i,
  input  logic             wpermit_i,
  input  logic [COL_W-1:0] rcol_i,
  output logic [7:0]       rdata_o,
  output logic             rvalid_o
);
  logic [7:0]            data_q [PAGE_BYTES];
  logic [PAGE_BYTES-1:0] mask_q;

  for (genvar g = 0; g < PAGE_BYTES; g++) begin : g_slot
    logic hit;
    assign hit = wr_i && (wcol_i == COL_W'(g));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        data_q[g] <= '0;
        mask_q[g] <= 1'b0;
      end else if (clear_i) begin
        mask_q[g] <= 1'b0;
      end else if (hit) begin
        data_q[g] <= wdata_i;
        mask_q[g] <= wpermit_i;
      end
    end
  end

  assign rdata_o  = data_q[rcol_i];
  assign rvalid_o = mask_q[rcol_i];
endmodule

// File: rtl/pwb_prog_timer.sv
module pwb_prog_timer #(
  parameter int TOTAL = 64,
  localparam int CNT_W = $clog2(TOTAL + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  output logic             busy_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic             last_o
);
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(TOTAL - 1);

  logic             busy_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (busy_q) begin
      if (cnt_q == LAST_CNT) begin
        busy_q <= 1'b0;
        cnt_q  <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end else if (start_i) begin
      busy_q <= 1'b1;
      cnt_q  <= '0;
    end
  end

  assign busy_o = busy_q;
  assign cnt_o  = cnt_q;
  assign last_o = busy_q && (cnt_q == LAST_CNT);
endmodule

// File: rtl/page_wr_ctrl.sv
module page_wr_ctrl
  import pwb_pkg::*;
#(
  parameter int ADDR_W      = 13,
  parameter int PAGE_BYTES  = 32,
  parameter int PROG_CYCLES = 1000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_start_i,
  input  logic [ADDR_W-1:0] start_addr_i,
  input  logic              wen_i,
  input  logic              byte_valid_i,
  input  logic [7:0]        byte_i,
  output logic [ADDR_W-1:0] load_addr_o,
  input  logic              permit_i,
  input  logic              cs_rise_i,
  input  logic [2:0]        bit_pos_i,
  input  logic              op_valid_i,
  input  logic              op_is_rdsr_i,
  output logic              op_accept_o,
  input  logic [7:0]        stat_i,
  output logic [7:0]        stat_o,
  output logic              arr_we_o,
  output logic [ADDR_W-1:0] arr_addr_o,
  output logic [7:0]        arr_data_o,
  output logic              busy_o,
  output logic              wen_clr_o
);
  localparam int COL_W  = $clog2(PAGE_BYTES);
  localparam int PAGE_W = ADDR_W - COL_W;
  localparam int TOTAL  = (PROG_CYCLES > PAGE_BYTES) ? PROG_CYCLES : PAGE_BYTES;
  localparam int CNT_W  = $clog2(TOTAL + 1);

  pwb_state_e        state_q;
  logic [PAGE_W-1:0] page_q;
  logic              got_q;
  logic [COL_W-1:0]  col;
  logic              accept_wr;
  logic              load_byte;
  logic              commit;
  logic              abandon;
  logic              tmr_busy;
  logic              tmr_last;
  logic [CNT_W-1:0]  tmr_cnt;
  logic              in_scan;
  logic [COL_W-1:0]  scan_col;
  logic [7:0]        scan_data;
  logic              scan_valid;

  assign accept_wr = (state_q == ST_IDLE) && wr_start_i && wen_i;
  assign load_byte = (state_q == ST_LOAD) && byte_valid_i && !cs_rise_i;
  assign commit    = (state_q == ST_LOAD) && cs_rise_i && got_q && (bit_pos_i == 3'd0);
  assign abandon   = (state_q == ST_LOAD) && cs_rise_i && !commit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      page_q  <= '0;
      got_q   <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (accept_wr) begin
            state_q <= ST_LOAD;
            page_q  <= start_addr_i[ADDR_W-1:COL_W];
            got_q   <= 1'b0;
          end
        end
        ST_LOAD: begin
          if (commit) begin
            state_q <= ST_PROG;
          end else if (abandon) begin
            state_q <= ST_IDLE;
          end else if (load_byte) begin
            got_q <= 1'b1;
          end
        end
        ST_PROG: begin
          if (tmr_last) state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  pwb_col_ctr #(.PAGE_BYTES(PAGE_BYTES)) u_col (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (accept_wr),
    .load_val_i (start_addr_i[COL_W-1:0]),
    .inc_i      (load_byte),
    .col_o      (col)
  );

  assign load_addr_o = {page_q, col};

  // scan column follows the timer for the first PAGE_BYTES busy cycles
  assign in_scan  = tmr_busy && (tmr_cnt < CNT_W'(PAGE_BYTES));
  assign scan_col = tmr_cnt[COL_W-1:0];

  pwb_page_latch #(.PAGE_BYTES(PAGE_BYTES)) u_latch (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clear_i   (accept_wr),
    .wr_i      (load_byte),
    .wcol_i    (col),
    .wdata_i   (byte_i),
    .wpermit_i (permit_i),
    .rcol_i    (scan_col),
    .rdata_o   (scan_data),
    .rvalid_o  (scan_valid)
  );

  pwb_prog_timer #(.TOTAL(TOTAL)) u_tmr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (commit),
    .busy_o  (tmr_busy),
    .cnt_o   (tmr_cnt),
    .last_o  (tmr_last)
  );

  assign arr_we_o    = in_scan && scan_valid;
  assign arr_addr_o  = {page_q, scan_col};
  assign arr_data_o  = scan_data;
  assign busy_o      = tmr_busy;
  assign wen_clr_o   = tmr_last;
  assign stat_o      = tmr_busy ? 8'hFF : stat_i;
  assign op_accept_o = op_valid_i && (!tmr_busy || op_is_rdsr_i);
endmodule

// File: rtl/page_wr_ctrl_chk.sv
module page_wr_ctrl_chk #(
  parameter int ADDR_W      = 13,
  parameter int PAGE_BYTES  = 32,
  parameter int PROG_CYCLES = 1000
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cs_rise_i,
  input logic [2:0]        bit_pos_i,
  input logic              op_valid_i,
  input logic              op_is_rdsr_i,
  input logic              op_accept_o,
  input logic              arr_we_o,
  input logic [ADDR_W-1:0] arr_addr_o,
  input logic              busy_o,
  input logic              wen_clr_o
);
  localparam int COL_W = $clog2(PAGE_BYTES);
  localparam int TOTAL = (PROG_CYCLES > PAGE_BYTES) ? PROG_CYCLES : PAGE_BYTES;
  localparam int LEN_W = $clog2(TOTAL + 2);

  logic [LEN_W-1:0] len_q;
  logic             prev_we_q;
  logic [ADDR_W-1:0] prev_addr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      len_q       <= '0;
      prev_we_q   <= 1'b0;
      prev_addr_q <= '0;
    end else begin
      len_q <= busy_o ? len_q + 1'b1 : '0;
      if (!busy_o) prev_we_q <= 1'b0;
      else if (arr_we_o) prev_we_q <= 1'b1;
      if (arr_we_o) prev_addr_q <= arr_addr_o;
    end
  end

  p_busy_len_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> len_q == LEN_W'(TOTAL));

  p_busy_bound_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> len_q < LEN_W'(TOTAL));

  p_start_boundary_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(cs_rise_i) && ($past(bit_pos_i) == 3'd0));

  p_clr_last_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wen_clr_o |-> busy_o ##1 !busy_o);

  p_we_busy_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    arr_we_o |-> busy_o);

  p_we_order_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (arr_we_o && prev_we_q) |->
      (arr_addr_o[ADDR_W-1:COL_W] == prev_addr_q[ADDR_W-1:COL_W]) &&
      (arr_addr_o[COL_W-1:0] > prev_addr_q[COL_W-1:0]));

  p_lockout_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && op_valid_i && !op_is_rdsr_i) |-> !op_accept_o);
endmodule

bind page_wr_ctrl page_wr_ctrl_chk #(
  .ADDR_W(ADDR_W), .PAGE_BYTES(PAGE_BYTES), .PROG_CYCLES(PROG_CYCLES)
) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .cs_rise_i    (cs_rise_i),
  .bit_pos_i    (bit_pos_i),
  .op_valid_i   (op_valid_i),
  .op_is_rdsr_i (op_is_rdsr_i),
  .op_accept_o  (op_accept_o),
  .arr_we_o     (arr_we_o),
  .arr_addr_o   (arr_addr_o),
  .busy_o       (busy_o),
  .wen_clr_o    (wen_clr_o)
);

// File: tb/page_wr_ctrl_bench.sv
`timescale 1ns/1ps
module page_wr_ctrl_bench;
  localparam int AW   = 8;
  localparam int PB   = 8;
  localparam int PC   = 20;
  localparam int TOT  = (PC > PB) ? PC : PB;
  localparam int NLOC = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_start = 1'b0;
  logic [AW-1:0] start_addr = '0;
  logic          wen = 1'b0;
  logic          byte_valid = 1'b0;
  logic [7:0]    byte_d = '0;
  logic [AW-1:0] load_addr;
  logic          permit;
  logic          cs_rise = 1'b0;
  logic [2:0]    bit_pos = '0;
  logic          op_valid = 1'b0;
  logic          op_rdsr = 1'b0;
  logic          op_accept;
  logic [7:0]    stat_in = 8'h02;
  logic [7:0]    stat_out;
  logic          arr_we;
  logic [AW-1:0] arr_addr;
  logic [7:0]    arr_data;
  logic          busy;
  logic          wen_clr;

  int unsigned   prot_lim = NLOC;
  int            total = 0;
  int            bad = 0;
  int            busy_cnt = 0;
  int            clr_cnt = 0;
  int            wr_cnt = 0;
  logic [7:0]    mem_obs [NLOC];
  logic [7:0]    mem_exp [NLOC];

  always #2.5 clk = ~clk;

  assign permit = (int'(load_addr) < prot_lim);

  page_wr_ctrl #(.ADDR_W(AW), .PAGE_BYTES(PB), .PROG_CYCLES(PC)) u_page_wr_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .wr_start_i(wr_start), .start_addr_i(start_addr),
    .wen_i(wen), .byte_valid_i(byte_valid), .byte_i(byte_d), .load_addr_o(load_addr),
    .permit_i(permit), .cs_rise_i(cs_rise), .bit_pos_i(bit_pos), .op_valid_i(op_valid),
    .op_is_rdsr_i(op_rdsr), .op_accept_o(op_accept), .stat_i(stat_in), .stat_o(stat_out),
    .arr_we_o(arr_we), .arr_addr_o(arr_addr), .arr_data_o(arr_data), .busy_o(busy),
    .wen_clr_o(wen_clr)
  );

  always @(negedge clk) begin
    if (busy) busy_cnt++;
    if (wen_clr) clr_cnt++;
    if (arr_we) begin
      wr_cnt++;
      mem_obs[arr_addr] = arr_data;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic clear_counts();
    busy_cnt = 0; clr_cnt = 0; wr_cnt = 0;
  endtask

  task automatic cmp_mem(input string req);
    int diffs = 0;
    for (int a = 0; a < NLOC; a++) if (mem_obs[a] !== mem_exp[a]) diffs++;
    chk(diffs == 0, req, diffs, 0);
  endtask

  // one write transaction; returns after programming (if any) is over
  task automatic do_write(input int txn, input int page, input int scol, input int n,
                          input bit we, input int bp, input bit probe);
    bit ld [PB];
    int nexp = 0;
    int a;
    logic [7:0] b;
    for (int c = 0; c < PB; c++) ld[c] = 1'b0;
    clear_counts();
    @(negedge clk);
    wen = we; wr_start = 1'b1; start_addr = AW'(page * PB + scol);
    @(negedge clk);
    wr_start = 1'b0;
    for (int k = 0; k < n; k++) begin
      a = page * PB + (scol + k) % PB;
      b = 8'((txn * 37 + k * 11 + 5) & 8'hFF);
      if (we) chk(load_addr == AW'(a), "R11", load_addr, a);
      if (we && bp == 0 && (a < int'(prot_lim))) begin
        ld[(scol + k) % PB] = 1'b1;
        mem_exp[a] = b;
      end
      byte_valid = 1'b1; byte_d = b;
      @(negedge clk);
      byte_valid = 1'b0;
    end
    cs_rise = 1'b1; bit_pos = 3'(bp);
    @(negedge clk);
    cs_rise = 1'b0; bit_pos = '0;
    if (probe) begin
      @(negedge clk);
      chk(busy == 1'b1, "R3", busy, 1);
      chk(stat_out == 8'hFF, "R4", stat_out, 8'hFF);
      op_valid = 1'b1; op_rdsr = 1'b1; #0.1;
      chk(op_accept == 1'b1, "R5", op_accept, 1);
      op_rdsr = 1'b0; #0.1;
      chk(op_accept == 1'b0, "R5", op_accept, 0);
      op_valid = 1'b0;
      // a write start during programming must leave no trace
      @(negedge clk);
      wen = 1'b1; wr_start = 1'b1; start_addr = AW'(((page + 3) % (NLOC / PB)) * PB);
      @(negedge clk);
      wr_start = 1'b0; byte_valid = 1'b1; byte_d = 8'hA5;
      @(negedge clk);
      byte_valid = 1'b0; cs_rise = 1'b1;
      @(negedge clk);
      cs_rise = 1'b0;
    end
    cyc(TOT + 4);
    for (int c = 0; c < PB; c++) if (ld[c]) nexp++;
    if (we && bp == 0 && n > 0) begin
      chk(busy_cnt == TOT, "R3", busy_cnt, TOT);
      chk(clr_cnt == 1, "R6", clr_cnt, 1);
      chk(wr_cnt == nexp, "R9", wr_cnt, nexp);
      cmp_mem("R1 R8 R9");
    end else begin
      chk(busy_cnt == 0, (!we) ? "R7" : (bp != 0) ? "R2" : "R10", busy_cnt, 0);
      chk(clr_cnt == 0, (bp != 0) ? "R2" : "R10", clr_cnt, 0);
      chk(wr_cnt == 0, (!we) ? "R7" : "R2", wr_cnt, 0);
    end
    if (probe) begin
      chk(stat_out == stat_in, "R4", stat_out, stat_in);
      op_valid = 1'b1; #0.1;
      chk(op_accept == 1'b1, "R5", op_accept, 1);
      op_valid = 1'b0;
    end
  endtask

  initial begin
    #1_000_000;
    bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int txn = 0;
    for (int a = 0; a < NLOC; a++) begin mem_obs[a] = '0; mem_exp[a] = '0; end
    cyc(3);
    chk(busy == 1'b0, "R3", busy, 0);
    chk(arr_we == 1'b0, "R9", arr_we, 0);
    chk(wen_clr == 1'b0, "R6", wen_clr, 0);
    rst_n = 1'b1;
    cyc(2);
    chk(stat_out == stat_in, "R4", stat_out, stat_in);
    // sweep start column and burst length, protection limit varies per page
    for (int s = 0; s < PB; s++) begin
      for (int n = 0; n <= PB + 3; n++) begin
        int page = (txn * 5 + 1) % (NLOC / PB);
        prot_lim = ((txn % 3) == 0) ? NLOC : page * PB + (s + 3) % (PB + 1);
        do_write(txn, page, s, n, 1'b1, 0, (txn % 17) == 3);
        txn++;
      end
    end
    prot_lim = NLOC;
    for (int bp = 1; bp < 8; bp++) begin
      do_write(txn, bp + 2, bp % PB, 2, 1'b1, bp, 1'b0);
      cmp_mem("R2");
      txn++;
    end
    do_write(txn, 9, 4, 3, 1'b0, 0, 1'b0);
    cmp_mem("R7");
    txn++;
    do_write(txn, 10, 0, 0, 1'b1, 0, 1'b0);
    cmp_mem("R10");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule